// File: doc/BRIEF.md
# Reset Sequencer with Open-Drain Pin Stretch

This block orders the release of the chip-wide reset. It takes three reset causes: an active-low power-on input, a vector of internal reset requests, and a bidirectional active-low reset pin. The pin is seen from two sides. One is an open-drain pull-down enable (`pin_oe`, high means the pad pulls the pin low). The other is the raw pin level (`pin_in`), which passes through a two-stage synchronizer before any decision is made on it.

While a reset cause is active, the block holds the internal reset low and pulls the pin low. After the last internal request goes away, it keeps pulling the pin for a stretch period. That period is long by default and short when the fast-recovery input is set. The block then lets go of the pin and waits a settle period. It then samples the synchronized pin. A pin that is still low is taken as an external request, and the block waits until the pin returns high. The boot-configuration input is captured a fixed four cycles before the internal reset is released. A small status register records why the chip was reset. Software clears it by writing ones, and a power-on reset clears it as well.

A low level on the pin forces the internal reset low at once, with no clock needed. The reset always returns high on a clock edge.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is 0, `pin_oe` is 1 and `stat` is 3'b001, whatever the values of `int_req`, `pin_in` and the other inputs. Status bit 0 means power-on, bit 1 means external and bit 2 means internal.
- R2: On the rising edge after any bit of `int_req` is high, `sys_rst_n` is 0 and `pin_oe` is 1, and status bit 2 is set.
- R3: `pin_oe` stays high for exactly LONG_CYC (1000) cycles after the edge at which no request is seen any more, or after the edge at which `por_n` is first seen high. The count is SHORT_CYC (16) when `fast_rec` is 1 at that edge.
- R4: If the pin stays high once released, `sys_rst_n` rises on the 37th rising edge (SETTLE_CYC+5) after the edge at which `pin_oe` falls.
- R5: If the pin is still held low at the 31st rising edge after `pin_oe` falls, status bit 1 is set. In that case `sys_rst_n` stays low until the 7th rising edge after the pin returns high, unless the R4 time is later.
- R6: `boot_cfg` takes the value that `boot_cfg_in` has at the rising edge four edges before the edge at which `sys_rst_n` rises, and it holds that value afterwards.
- R7: A low level on `pin_in` forces `sys_rst_n` low immediately. If the pin is held low for three or more cycles while running, the block re-samples it without pulling the pin. It sets status bit 1 and releases the reset on the 7th rising edge after the pin returns high.
- R8: When `clr_we` is high at an edge, each status bit whose `clr_mask` bit is 1 is cleared and the other bits keep their value. A flag set in the same cycle wins over the clear. Bit 0 is never set except by power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| int_req | input | NUM_REQ (4) | Internal reset requests, active high |
| pin_in | input | 1 | Raw level of the reset pin |
| fast_rec | input | 1 | Selects the short stretch period |
| boot_cfg_in | input | 1 | Boot-configuration level to capture |
| clr_we | input | 1 | Write strobe for status clearing |
| clr_mask | input | 3 | Write-one-to-clear mask for the status |
| pin_oe | output | 1 | Pin pull-down enable (1 = drive pin low) |
| sys_rst_n | output | 1 | Internal reset, active low |
| boot_cfg | output | 1 | Captured boot configuration |
| stat | output | 3 | Reset-cause flags: bit0 power-on, bit1 external, bit2 internal |

## Verification
A wrong state or a counter that is off by one shows at the ports as a `pin_oe` pulse of the wrong length, seen within one stretch period. It can also show as a `sys_rst_n` rise at the wrong edge, which appears a few dozen cycles later. A wrong capture point shows as a `boot_cfg` value that matches the input from the wrong cycle. To catch this, the bench drives a different random level on `boot_cfg_in` every cycle. A fault in the sampling or synchronizer path shows as a wrong external flag or a wrong release time when the pin is let go around the sample boundary. The bench tries both sides of that boundary.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_POR,
        ST_INT_ACT,
        ST_STRETCH,
        ST_SETTLE,
        ST_SAMPLE,
        ST_LATCH_CFG,
        ST_RUN
    } rst_state_e;

    localparam int NUM_FLAGS = 3;
    localparam int FLAG_POR  = 0;
    localparam int FLAG_EXT  = 1;
    localparam int FLAG_INT  = 2;

endpackage

// File: rtl/rst_pin_sync.sv
`timescale 1ns/1ps
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    // Reset to 0: the pin counts as low until it is really observed high.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/rst_stat_reg.sv
`timescale 1ns/1ps
module rst_stat_reg #(
    parameter int            NF      = 3,
    parameter logic [NF-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic [NF-1:0] set_i,
    input  logic          clr_we,
    input  logic [NF-1:0] clr_mask,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_we) flags_d = flags_d & ~clr_mask;
        flags_d = flags_d | set_i;   // a new event beats a clear
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) flags_q <= RST_VAL;
        else         flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/rst_seq_ctrl.sv
`timescale 1ns/1ps
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int NUM_REQ     = 4,
    parameter int LONG_CYC    = 1000,
    parameter int SHORT_CYC   = 16,
    parameter int SETTLE_CYC  = 32,
    parameter int CFG_LEAD    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic [NUM_REQ-1:0]   int_req,
    input  logic                 pin_in,
    input  logic                 fast_rec,
    input  logic                 boot_cfg_in,
    input  logic                 clr_we,
    input  logic [NUM_FLAGS-1:0] clr_mask,
    output logic                 pin_oe,
    output logic                 sys_rst_n,
    output logic                 boot_cfg,
    output logic [NUM_FLAGS-1:0] stat
);
    localparam int MAX_A = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int MAX_B = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
    localparam int MAX_C = (MAX_B > CFG_LEAD) ? MAX_B : CFG_LEAD;
    localparam int CW    = $clog2(MAX_C + 1);

    typedef logic [CW-1:0] cnt_t;

    localparam cnt_t LONG_LD   = cnt_t'(LONG_CYC - 1);
    localparam cnt_t SHORT_LD  = cnt_t'(SHORT_CYC - 1);
    localparam cnt_t SETTLE_LD = cnt_t'(SETTLE_CYC - 1);
    localparam cnt_t CFG_LD    = cnt_t'(CFG_LEAD - 1);
    localparam logic [NUM_FLAGS-1:0] STAT_RST = (NUM_FLAGS)'(1) << FLAG_POR;

    typedef struct packed {
        rst_state_e st;
        cnt_t       cnt;
        logic       cfg;
    } seq_t;

    seq_t                 cur_q, nxt_d;
    logic                 pin_s;
    logic                 req_any;
    logic [NUM_FLAGS-1:0] set_d;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (por_n),
        .din    (pin_in),
        .dout   (pin_s)
    );

    always_comb begin
        nxt_d            = cur_q;
        req_any          = |int_req;
        set_d            = '0;
        set_d[FLAG_INT]  = req_any;
        unique case (cur_q.st)
            ST_POR, ST_INT_ACT: begin
                if (req_any) begin
                    nxt_d.st = ST_INT_ACT;
                end else begin
                    nxt_d.st  = ST_STRETCH;
                    nxt_d.cnt = fast_rec ? SHORT_LD : LONG_LD;
                end
            end
            ST_STRETCH: begin
                if (cur_q.cnt == '0) begin
                    nxt_d.st  = ST_SETTLE;
                    nxt_d.cnt = SETTLE_LD;
                end else begin
                    nxt_d.cnt = cur_q.cnt - cnt_t'(1);
                end
            end
            ST_SETTLE: begin
                if (cur_q.cnt == '0) nxt_d.st  = ST_SAMPLE;
                else                 nxt_d.cnt = cur_q.cnt - cnt_t'(1);
            end
            ST_SAMPLE: begin
                if (pin_s) begin
                    nxt_d.st  = ST_LATCH_CFG;
                    nxt_d.cnt = CFG_LD;
                    nxt_d.cfg = boot_cfg_in;
                end else begin
                    set_d[FLAG_EXT] = 1'b1;
                end
            end
            ST_LATCH_CFG: begin
                if (cur_q.cnt == '0) nxt_d.st  = ST_RUN;
                else                 nxt_d.cnt = cur_q.cnt - cnt_t'(1);
            end
            ST_RUN: begin
                if (!pin_s) begin
                    nxt_d.st        = ST_SAMPLE;
                    set_d[FLAG_EXT] = 1'b1;
                end
            end
            default: nxt_d.st = ST_POR;
        endcase
        // An internal request restarts the sequence from any state.
        if (req_any) nxt_d.st = ST_INT_ACT;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cur_q <= '{st: ST_POR, cnt: '0, cfg: 1'b0};
        else        cur_q <= nxt_d;
    end

    rst_stat_reg #(.NF(NUM_FLAGS), .RST_VAL(STAT_RST)) u_stat (
        .clk      (clk),
        .arst_n   (por_n),
        .set_i    (set_d),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .flags    (stat)
    );

    assign pin_oe    = (cur_q.st == ST_POR) || (cur_q.st == ST_INT_ACT) ||
                       (cur_q.st == ST_STRETCH);
    // The raw pin takes the reset down at once; it can only come back on a clock edge.
    assign sys_rst_n = (cur_q.st == ST_RUN) && pin_in;
    assign boot_cfg  = cur_q.cfg;
endmodule

// File: rtl/rst_seq_chk.sv
`timescale 1ns/1ps
module rst_seq_chk #(
    parameter int NUM_REQ = 4
) (
    input logic               clk,
    input logic               por_n,
    input logic [NUM_REQ-1:0] int_req,
    input logic               pin_in,
    input logic               pin_oe,
    input logic               sys_rst_n,
    input logic [2:0]         stat
);
    always @(posedge clk) begin
        // R1
        if (!por_n) begin
            por_hold_chk: assert (!sys_rst_n && pin_oe);
        end
        // R7
        if (!pin_in) begin
            pin_low_chk: assert (!sys_rst_n);
        end
    end

    // R2
    req_oe_chk: assert property (@(posedge clk) disable iff (!por_n)
        (|int_req) |=> (pin_oe && !sys_rst_n));

    // R4
    oe_fall_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pin_oe) |-> !sys_rst_n);

    // R5
    ext_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(stat[1]) |-> !$past(pin_in, 3));

    // R8
    por_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$rose(stat[0]));
endmodule

bind rst_seq_ctrl rst_seq_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .int_req   (int_req),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .sys_rst_n (sys_rst_n),
    .stat      (stat)
);

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rst_seq_ctrl;
    localparam int NREQ   = 4;
    localparam int SETTLE = 32;

    logic            clk = 1'b0;
    logic            por_n = 1'b0;
    logic [NREQ-1:0] int_req = '0;
    logic            fast_rec = 1'b0;
    logic            boot_cfg_in = 1'b0;
    logic            clr_we = 1'b0;
    logic [2:0]      clr_mask = '0;
    logic            ext_low = 1'b0;
    logic            pin_in, pin_oe, sys_rst_n, boot_cfg;
    logic [2:0]      stat;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit cfg_hist [0:2199];

    always #4 clk = ~clk;

    // Open-drain pin: low when the block or the outside world pulls it.
    assign pin_in = !(pin_oe || ext_low);

    rst_seq_ctrl u0 (
        .clk(clk), .por_n(por_n), .int_req(int_req), .pin_in(pin_in),
        .fast_rec(fast_rec), .boot_cfg_in(boot_cfg_in), .clr_we(clr_we),
        .clr_mask(clr_mask), .pin_oe(pin_oe), .sys_rst_n(sys_rst_n),
        .boot_cfg(boot_cfg), .stat(stat)
    );

    function automatic int stretch_len(bit f);
        return f ? 16 : 1000;
    endfunction

    // Negedge index at which sys_rst_n is first seen high.
    function automatic int exp_rise(int n, int m);
        int a = n + SETTLE + 6;
        int b = m + 7;
        return (m > 0 && b > a) ? b : a;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called just after a negedge; releases the reset cause there.
    task automatic release_seq(input bit fast, input int m, input bit from_por);
        int  n = stretch_len(fast);
        int  oe_cnt = 0;
        bit  oe_run = 1;
        int  k_hi = -1;
        bit  ext_exp;
        logic [2:0] st_exp;
        fast_rec = fast;
        if (m > 0) ext_low = 1'b1;
        if (from_por) por_n = 1'b1;
        else          int_req = '0;
        for (int k = 1; k <= 2150 && k_hi < 0; k++) begin
            @(negedge clk);
            if (oe_run && pin_oe) oe_cnt++;
            else                  oe_run = 0;
            if (sys_rst_n) k_hi = k;
            if (k == m) ext_low = 1'b0;
            boot_cfg_in = 1'($urandom);
            cfg_hist[k] = boot_cfg_in;
        end
        ext_low = 1'b0;
        chk(oe_cnt == n, "R3 stretch length", oe_cnt, n);
        if (m > 0) chk(k_hi == exp_rise(n, m), "R5 release time", k_hi, exp_rise(n, m));
        else       chk(k_hi == exp_rise(n, m), "R4 release time", k_hi, exp_rise(n, m));
        if (k_hi > 5)
            chk(boot_cfg == cfg_hist[k_hi-5], "R6 boot capture", int'(boot_cfg), int'(cfg_hist[k_hi-5]));
        ext_exp = (m > 0) && (m >= n + SETTLE);
        st_exp  = {~from_por, ext_exp, from_por};
        chk(stat == st_exp, "R5 status flags", int'(stat), int'(st_exp));
    endtask

    // From run: assert an internal request together with a full clear.
    task automatic internal_seq(input bit fast, input int m, input int hold);
        clr_we = 1'b1; clr_mask = 3'b111;
        int_req = NREQ'($urandom_range(1, (1 << NREQ) - 1));
        @(negedge clk);
        clr_we = 1'b0;
        chk(stat == 3'b100, "R8 set beats clear", int'(stat), 4);
        for (int i = 0; i < hold; i++) begin
            chk(pin_oe && !sys_rst_n, "R2 request drives pin", int'({pin_oe, sys_rst_n}), 2);
            @(negedge clk);
        end
        release_seq(fast, m, 1'b0);
    endtask

    // From run: outside world pulls the pin for h cycles.
    task automatic ext_pulse(input int h);
        int  k_hi = -1;
        bit  oe_seen = 0;
        clr_we = 1'b1; clr_mask = 3'b111;
        ext_low = 1'b1;
        #1;
        chk(!sys_rst_n, "R7 immediate assert", int'(sys_rst_n), 0);
        @(negedge clk);
        clr_we = 1'b0;
        for (int k = 1; k <= 400 && k_hi < 0; k++) begin
            if (k > 1) @(negedge clk);
            if (pin_oe) oe_seen = 1;
            if (sys_rst_n) k_hi = k;
            if (k == h) ext_low = 1'b0;
            boot_cfg_in = 1'($urandom);
            cfg_hist[k] = boot_cfg_in;
        end
        chk(!oe_seen, "R7 pin not driven", int'(oe_seen), 0);
        chk(k_hi == h + 7, "R7 release time", k_hi, h + 7);
        chk(boot_cfg == cfg_hist[k_hi-5], "R6 boot capture ext", int'(boot_cfg), int'(cfg_hist[k_hi-5]));
        chk(stat == 3'b010, "R7 external flag", int'(stat), 2);
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R1: power-on holds everything regardless of other inputs
        int_req = 4'b0101;
        ext_low = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!sys_rst_n && pin_oe, "R1 por outputs", int'({pin_oe, sys_rst_n}), 2);
            chk(stat == 3'b001, "R1 por status", int'(stat), 1);
            int_req = NREQ'($urandom);
        end
        int_req = '0;
        ext_low = 1'b0;
        release_seq(1'b1, 0, 1'b1);

        // R3 long stretch, then a set of short ones around the sample boundary
        internal_seq(1'b0, 0, 3);
        internal_seq(1'b1, 47, 1);
        internal_seq(1'b1, 48, 2);
        for (int r = 0; r < 10; r++)
            internal_seq(1'b1, int'($urandom_range(0, 80)), int'($urandom_range(1, 6)));

        // R7 external pulls while running
        ext_pulse(3);
        ext_pulse(int'($urandom_range(4, 40)));

        // R8 partial clear: only masked bits go
        clr_we = 1'b1; clr_mask = 3'b101;
        @(negedge clk);
        chk(stat == 3'b010, "R8 unmasked bit kept", int'(stat), 2);
        clr_mask = 3'b010;
        @(negedge clk);
        clr_we = 1'b0;
        chk(stat == 3'b000, "R8 masked bit cleared", int'(stat), 0);
        repeat (3) @(negedge clk);
        chk(stat == 3'b000 && sys_rst_n, "R8 stays clear in run", int'(stat), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule